// File: doc/BRIEF.md
# Four-word serial test burst transmitter

This block sends a fixed-length burst of four 32-bit words out on one serial pin, together with a companion bit clock for an external receiver or a logic analyser. The producer presents all four words in parallel and pulses `start_i` for one cycle. The words are captured on that edge and `busy_o` rises. The burst then runs for exactly 140 fast-clock cycles, one bit per cycle.

Each word occupies a 33-bit slot. The slot starts with a marker bit driven high, and the 32 data bits follow least significant bit first, so bit 31 (the sign) closes the slot. Word 0 is sent first. The four slots fill 132 cycles, and the remaining cycles up to the burst length are driven low. The producer schedules its strobes so that each burst ends before the next one is due. A strobe that arrives during a burst is dropped and recorded in a sticky overrun flag.

Top module: `word_burst_tx`

## Requirements
- R1: After reset, `busy_o`, `ser_o`, `bit_clk_o` and `overrun_o` are all low.
- R2: `start_i` sampled high while `busy_o` is low starts a burst. `busy_o` is high from the next cycle, and the four words on `word_i` are captured on that edge. Word n is `word_i[32n+31:32n]`.
- R3: `busy_o` stays high for exactly 140 consecutive cycles per burst.
- R4: Bit index k of a burst (k = 0 in the first busy cycle) with k < 132 belongs to word k/33 at slot position p = k mod 33. When p = 0, `ser_o` is 1 (the marker). Otherwise `ser_o` is data bit p-1 of that word, so bit 0 comes first and bit 31 comes last.
- R5: For bit indices 132 to 139, `ser_o` is low.
- R6: During bits 0 to 131, `bit_clk_o` equals bit 0 of the bit index, so it changes level once per bit. During bits 132 to 139 it is low.
- R7: Changes on `word_i` after the accepting edge have no effect on the burst in progress.
- R8: `start_i` sampled high while `busy_o` is high is ignored: the running burst is unchanged and keeps its length. It also sets `overrun_o`, which stays high until reset.
- R9: While `busy_o` is low, `ser_o` and `bit_clk_o` are low.
- R10: A start on the first cycle after `busy_o` falls is accepted, so bursts can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, one bit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle burst start strobe |
| word_i | input | 128 | Four words, word 0 in the low 32 bits |
| ser_o | output | 1 | Serial data line |
| bit_clk_o | output | 1 | Companion bit clock |
| busy_o | output | 1 | High while a burst is in progress |
| overrun_o | output | 1 | Sticky flag: a start arrived while busy |

## Verification
The stream is compared bit for bit against a model for several word sets, and each set exposes a different fault:
- All zeros isolates the marker bits and their positions.
- All ones shows whether the padding is correctly low.
- A single set low bit and a single set high bit in each word separate LSB-first order from MSB-first order.
- Four distinct words catch swapped slots.
- Alternating 0101 and 1010 patterns catch an off-by-one shift.

Directed bursts change `word_i` in mid-burst and inject a second strobe during a burst. A further burst starts on the first idle cycle to check back-to-back operation.

// File: rtl/wbt_pkg.sv
package wbt_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_FLAG = 2'd1,
    PH_DATA = 2'd2,
    PH_PAD  = 2'd3
  } phase_e;
endpackage

// File: rtl/wbt_seq.sv
module wbt_seq
  import wbt_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int WORD_W    = 32,
  parameter int BURST_LEN = 140
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  output logic   busy_o,
  output logic   load_o,
  output logic   shift_o,
  output logic   odd_o,
  output phase_e phase_o
);
  localparam int SLOT   = WORD_W + 1;
  localparam int ACTIVE = NUM_WORDS * SLOT;
  localparam int CNT_W  = $clog2(BURST_LEN + 1);
  localparam int POS_W  = $clog2(SLOT + 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [POS_W-1:0] pos_q;
  logic             accept;

  assign accept = start_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      pos_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      pos_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(BURST_LEN - 1)) busy_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
      pos_q <= (pos_q == POS_W'(SLOT - 1)) ? '0 : pos_q + 1'b1;
    end
  end

  always_comb begin
    if (!busy_q)                         phase_o = PH_IDLE;
    else if (cnt_q >= CNT_W'(ACTIVE))    phase_o = PH_PAD;
    else if (pos_q == '0)                phase_o = PH_FLAG;
    else                                 phase_o = PH_DATA;
  end

  assign busy_o  = busy_q;
  assign load_o  = accept;
  // advance the data register after each data bit has been on the line
  assign shift_o = (phase_o == PH_DATA);
  assign odd_o   = cnt_q[0];
endmodule

// File: rtl/wbt_shreg.sv
module wbt_shreg #(
  parameter int NUM_WORDS = 4,
  parameter int WORD_W    = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic                        shift_i,
  input  logic [NUM_WORDS*WORD_W-1:0] word_i,
  output logic                        bit_o
);
  logic [WORD_W-1:0] lane_q [NUM_WORDS];

  // lanes chained: lane n refills from lane n+1 so word n+1 follows word n
  for (genvar n = 0; n < NUM_WORDS; n++) begin : g_lane
    logic fill;
    if (n == NUM_WORDS - 1) begin : g_last
      assign fill = 1'b0;
    end else begin : g_mid
      assign fill = lane_q[n+1][0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      lane_q[n] <= '0;
      else if (load_i)  lane_q[n] <= word_i[n*WORD_W +: WORD_W];
      else if (shift_i) lane_q[n] <= {fill, lane_q[n][WORD_W-1:1]};
    end
  end

  assign bit_o = lane_q[0][0];
endmodule

// File: rtl/wbt_out.sv
module wbt_out
  import wbt_pkg::*;
(
  input  phase_e phase_i,
  input  logic   data_i,
  input  logic   odd_i,
  output logic   ser_o,
  output logic   bit_clk_o
);
  always_comb begin
    unique case (phase_i)
      PH_FLAG: ser_o = 1'b1;
      PH_DATA: ser_o = data_i;
      default: ser_o = 1'b0;
    endcase
  end

  assign bit_clk_o = ((phase_i == PH_FLAG) || (phase_i == PH_DATA)) && odd_i;
endmodule

// File: rtl/word_burst_tx.sv
module word_burst_tx
  import wbt_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int WORD_W    = 32,
  parameter int BURST_LEN = 140
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [NUM_WORDS*WORD_W-1:0] word_i,
  output logic                        ser_o,
  output logic                        bit_clk_o,
  output logic                        busy_o,
  output logic                        overrun_o
);
  phase_e phase;
  logic   load, shift, odd, data_bit, overrun_q;

  wbt_seq #(
    .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .BURST_LEN(BURST_LEN)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
    .load_o(load), .shift_o(shift), .odd_o(odd), .phase_o(phase)
  );

  wbt_shreg #(
    .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)
  ) u_shreg (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .shift_i(shift),
    .word_i(word_i), .bit_o(data_bit)
  );

  wbt_out u_out (
    .phase_i(phase), .data_i(data_bit), .odd_i(odd),
    .ser_o(ser_o), .bit_clk_o(bit_clk_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                overrun_q <= 1'b0;
    else if (start_i && busy_o) overrun_q <= 1'b1;
  end

  assign overrun_o = overrun_q;
endmodule

// File: rtl/wbt_chk.sv
module wbt_chk #(
  parameter int BURST_LEN = 140
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic ser_o,
  input logic bit_clk_o,
  input logic busy_o,
  input logic overrun_o
);
  logic [15:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  // R2
  start_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && ser_o && !bit_clk_o);

  // R3
  burst_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_q == 16'(BURST_LEN));

  // R8
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && busy_o |=> overrun_o);

  // R8
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !ser_o && !bit_clk_o);
endmodule

bind word_burst_tx wbt_chk #(.BURST_LEN(BURST_LEN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .ser_o(ser_o),
  .bit_clk_o(bit_clk_o), .busy_o(busy_o), .overrun_o(overrun_o)
);

// File: tb/tb_word_burst_tx.sv
`timescale 1ns/1ps
module tb_word_burst_tx;
  localparam int NW = 4, WW = 32, BL = 140, SLOT = WW + 1, ACT = NW * SLOT;

  logic clk = 0, rst_n = 0, start = 0;
  logic [NW*WW-1:0] words = '0;
  logic ser, bclk, busy, ovr;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  word_burst_tx #(.NUM_WORDS(NW), .WORD_W(WW), .BURST_LEN(BL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .word_i(words),
    .ser_o(ser), .bit_clk_o(bclk), .busy_o(busy), .overrun_o(ovr)
  );

  localparam logic [127:0] VECS [5] = '{
    128'h0,
    {128{1'b1}},
    {32'h8000_0000, 32'h0000_0001, 32'h8000_0000, 32'h0000_0001},
    {32'hDEAD_BEEF, 32'h1234_5678, 32'h0F0F_00FF, 32'hC001_D00D},
    {32'hAAAA_AAAA, 32'h5555_5555, 32'hAAAA_AAAA, 32'h5555_5555}
  };

  function automatic logic exp_ser(input logic [127:0] w, input int k);
    int s, p;
    if (k >= ACT) return 1'b0;
    s = k / SLOT; p = k % SLOT;
    if (p == 0) return 1'b1;
    return w[s*WW + p - 1];
  endfunction

  function automatic logic exp_clk(input int k);
    return (k < ACT) ? k[0] : 1'b0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // runs one burst from a negedge with busy low; returns at the negedge after it
  task automatic run_burst(input logic [127:0] w, input bit scramble, input bit extra);
    int ser_bad = 0, clk_bad = 0, busy_bad = 0, first = -1;
    words = w; start = 1;
    @(negedge clk); start = 0;
    for (int k = 0; k < BL; k++) begin
      if (busy !== 1'b1) busy_bad++;
      if (ser !== exp_ser(w, k)) begin ser_bad++; if (first < 0) first = k; end
      if (bclk !== exp_clk(k)) clk_bad++;
      if (scramble && k == 10) words = ~w;
      start = (extra && k == 50);
      @(negedge clk);
    end
    start = 0;
    if (first >= 0) $display("  first serial mismatch at bit %0d", first);
    chk("R4/R5/R7 serial mismatching bits", ser_bad, 0);
    chk("R6 bit clock mismatching bits", clk_bad, 0);
    chk("R3 busy low inside burst", busy_bad, 0);
    chk("R3 busy low after 140", busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 R9 reset state
    chk("R1 busy", busy, 0); chk("R1 ser", ser, 0);
    chk("R1 bit_clk", bclk, 0); chk("R1 overrun", ovr, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R9 idle ser", ser, 0); chk("R9 idle bit_clk", bclk, 0);

    // R2 R4 R5 R6: table walk
    for (int v = 0; v < 5; v++) begin
      run_burst(VECS[v], 1'b0, 1'b0);
      chk("R2 no overrun on clean burst", ovr, 0);
      @(negedge clk);
    end

    // R7 inputs change mid-burst
    run_burst(VECS[3], 1'b1, 1'b0);
    chk("R7 overrun untouched", ovr, 0);

    // R10 back-to-back start on first idle cycle
    run_burst(VECS[2], 1'b0, 1'b0);
    chk("R10 back-to-back overrun clear", ovr, 0);

    // R8 start while busy
    run_burst(VECS[4], 1'b0, 1'b1);
    chk("R8 overrun set", ovr, 1);
    repeat (5) @(negedge clk);
    chk("R8 overrun sticky", ovr, 1);
    chk("R9 idle ser after burst", ser, 0);

    // R1 reset clears overrun
    rst_n = 0;
    @(negedge clk);
    chk("R1 overrun cleared", ovr, 0);
    chk("R1 busy cleared", busy, 0);
    rst_n = 1;
    @(negedge clk);
    run_burst(VECS[3], 1'b0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule